// File: doc/BRIEF.md
# Command Bus Monitor with Per-Bank Row Tracking

This block watches the command pins of a four-bank low-power DDR SDRAM interface. On every rising clock edge it samples chip select, the three strobe lines (RAS#, CAS#, WE#), two bank bits and thirteen address bits. It decodes these into a command. It then checks that command against the state it keeps for each bank: whether a row is open, which row it is, and whether a self-closing burst is still running.

Legal commands update the bank table. Illegal ones leave it alone and raise a one-cycle violation pulse with a cause code. The block also holds the last mode value loaded and enforces a programmable settle window after each mode load. It closes a bank by itself when a burst that asked for auto-precharge ends. During write data cycles it turns the data-mask pins into per-lane write enables.

All outputs are registered. A command sampled at clock edge k shows its effect on the outputs just after edge k. The block has no data stream, so it has no valid/ready handshake. Every pin is plain control or status, and the bus is observed and never stalled.

Top module: `cmdbus_bank_monitor`

## Requirements
- R1: Decoding uses the pins in the order (cs_n, ras_n, cas_n, we_n):
  - ACTIVE is 0,0,1,1.
  - READ is 0,1,0,1.
  - WRITE is 0,1,0,0.
  - PRECHARGE is 0,0,1,0.
  - MODE LOAD is 0,0,0,0.
  - NOP is 0,1,1,1.
  - Any cycle with cs_n high is a deselect.
  - Deselect, NOP and the two remaining encodings change no bank state and raise no violation. Bursts already in flight keep running through them.
- R2: After reset, the outputs are as follows:
  - bank_open, burst_pend, byte_wr_en, viol, viol_cause, cmd_ok and mode_wait are all zero.
  - mode_val is zero.
- R3: An accepted ACTIVE sets bank_open[ba] and stores addr as that bank's row in open_rows[ba*13 +: 13]. An ACTIVE to a bank that is already open raises viol with cause 2 and changes nothing.
- R4: PRECHARGE with addr[10] low closes only bank ba. With addr[10] high it closes all banks. Precharging an idle bank is legal and has no effect.
- R5: MODE LOAD is accepted only when no bank is open. It then latches {ba, addr} into mode_val. Otherwise it raises viol with cause 1 and mode_val keeps its value.
- R6: Let W be the value of mrd_wait when a MODE LOAD is accepted at edge k. Every command other than NOP or deselect sampled at edges k+1 through k+W-1 raises viol with cause 4 and has no effect. This cause takes priority over the others. mode_wait is high across that window. A W of 0 or 1 gives no window.
- R7: A READ or WRITE to a bank with no open row raises viol with cause 3, and bank state does not change.
- R8: mode_val[2:0] sets the burst: 1 gives 2 beats, 2 gives 4 beats, 3 gives 8 beats, and any other code is treated as 2. A READ or WRITE accepted at edge k with addr[10] high sets burst_pend for that bank. The bank closes at edge k + beats/2. With addr[10] low the row stays open.
- R9: A WRITE accepted at edge k opens a data window at edges k+1 through k+beats/2. In that window each lane's byte_wr_en is the inverse of its dm bit sampled at the same edge, so a low mask enables the lane. Outside the window byte_wr_en is zero.
- R10: viol and cmd_ok are one-cycle pulses for the command sampled at the preceding edge, and they are never high together. cmd_ok marks an accepted ACTIVE, READ, WRITE, PRECHARGE or MODE LOAD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low selects |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| ba | input | 2 | Bank select |
| addr | input | 13 | Row, column or mode bits; bit 10 is the precharge qualifier |
| dm | input | 2 | Data mask per byte lane, high blocks the lane |
| mrd_wait | input | 4 | Settle window length in cycles after a mode load |
| bank_open | output | 4 | One bit per bank, high when a row is open |
| open_rows | output | 52 | Open row per bank, 13 bits each, bank 0 lowest |
| burst_pend | output | 4 | Auto-precharge burst in progress per bank |
| mode_val | output | 15 | Last accepted mode value {ba, addr} |
| mode_wait | output | 1 | High inside the post-load settle window |
| byte_wr_en | output | 2 | Per-lane write enable during write data cycles |
| cmd_ok | output | 1 | Pulse: command accepted |
| viol | output | 1 | Pulse: protocol violation |
| viol_cause | output | 3 | Violation cause: 1 load while open, 2 activate open bank, 3 access idle bank, 4 inside settle window |

## Verification
Several rules are checked by assertions on every cycle:
- Idle cycles leave the bank table alone when no burst is pending.
- Accept and violation never pulse together.
- A pending burst always sits on an open bank.
- A mode load is only ever accepted with every bank idle.
- Any command inside the settle window is flagged.
- Rows never change on a violation.
- A masked lane is never enabled.

Only the bench scenarios show the exact cycle on which an auto-precharge bank closes for each burst length, the lane enables across a whole write window, and the boundary edge where the settle window ends. They also show that precharge-all and single-bank precharge reach the intended banks.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_MODE,
    CMD_OTHER
  } cmd_e;

  localparam logic [2:0] CAUSE_NONE     = 3'd0;
  localparam logic [2:0] CAUSE_LOAD_OPEN = 3'd1;
  localparam logic [2:0] CAUSE_ACT_OPEN = 3'd2;
  localparam logic [2:0] CAUSE_IDLE_ACC = 3'd3;
  localparam logic [2:0] CAUSE_SETTLE   = 3'd4;

  // clock cycles per burst (two data beats per clock)
  function automatic logic [3:0] burst_cycles(input logic [2:0] code);
    case (code)
      3'd2:    burst_cycles = 4'd2;
      3'd3:    burst_cycles = 4'd4;
      default: burst_cycles = 4'd1;
    endcase
  endfunction

endpackage

// File: rtl/cbm_decode.sv
module cbm_decode
  import cbm_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESEL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b000:  cmd = CMD_MODE;
        default: cmd = CMD_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/cbm_settle_timer.sv
module cbm_settle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             busy
);
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left <= '0;
    end else if (load) begin
      left <= (len == '0) ? '0 : len - 1'b1;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);
endmodule

// File: rtl/cbm_bank_slot.sv
module cbm_bank_slot #(
  parameter int ROW_W = 13,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_open,
  input  logic             do_close,
  input  logic             do_burst,
  input  logic             burst_ap,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row,
  output logic             ap_pend
);
  logic [LEN_W-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_open <= 1'b0;
      row     <= '0;
      left    <= '0;
      ap_pend <= 1'b0;
    end else if (do_close) begin
      is_open <= 1'b0;
      left    <= '0;
      ap_pend <= 1'b0;
    end else if (do_open) begin
      is_open <= 1'b1;
      row     <= row_in;
    end else if (do_burst) begin
      left    <= burst_len;
      ap_pend <= burst_ap;
    end else if (left != '0) begin
      left <= left - 1'b1;
      if (left == LEN_W'(1)) begin
        ap_pend <= 1'b0;
        if (ap_pend) is_open <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cmdbus_bank_monitor.sv
module cmdbus_bank_monitor
  import cbm_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int ROW_W  = 13,
  parameter int LANES  = 2,
  parameter int MRD_W  = 4,
  parameter int AP_BIT = 10,
  localparam int BA_W  = $clog2(NBANK),
  localparam int MODE_W = BA_W + ROW_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic [BA_W-1:0]        ba,
  input  logic [ROW_W-1:0]       addr,
  input  logic [LANES-1:0]       dm,
  input  logic [MRD_W-1:0]       mrd_wait,
  output logic [NBANK-1:0]       bank_open,
  output logic [NBANK*ROW_W-1:0] open_rows,
  output logic [NBANK-1:0]       burst_pend,
  output logic [MODE_W-1:0]      mode_val,
  output logic                   mode_wait,
  output logic [LANES-1:0]       byte_wr_en,
  output logic                   cmd_ok,
  output logic                   viol,
  output logic [2:0]             viol_cause
);
  localparam int LEN_W = 4;

  cmd_e       cmd;
  logic [2:0] cause;
  logic       executable;
  logic       accept;
  logic [LEN_W-1:0] blen;
  logic [LEN_W-1:0] wr_left;

  cbm_decode u_dec (
    .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  cbm_settle_timer #(.CNT_W(MRD_W)) u_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .load (accept && cmd == CMD_MODE),
    .len  (mrd_wait),
    .busy (mode_wait)
  );

  assign blen       = burst_cycles(mode_val[2:0]);
  assign executable = (cmd != CMD_DESEL) && (cmd != CMD_NOP);

  // legality against the bank table; settle window wins
  always_comb begin
    cause = CAUSE_NONE;
    if (executable && mode_wait) begin
      cause = CAUSE_SETTLE;
    end else begin
      case (cmd)
        CMD_MODE: if (bank_open != '0)     cause = CAUSE_LOAD_OPEN;
        CMD_ACT:  if (bank_open[ba])       cause = CAUSE_ACT_OPEN;
        CMD_RD,
        CMD_WR:   if (!bank_open[ba])      cause = CAUSE_IDLE_ACC;
        default:  cause = CAUSE_NONE;
      endcase
    end
  end

  assign accept = executable && (cmd != CMD_OTHER) && (cause == CAUSE_NONE);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(b));
    cbm_bank_slot #(.ROW_W(ROW_W), .LEN_W(LEN_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_open  (accept && cmd == CMD_ACT && hit),
      .do_close (accept && cmd == CMD_PRE && (hit || addr[AP_BIT])),
      .do_burst (accept && (cmd == CMD_RD || cmd == CMD_WR) && hit),
      .burst_ap (addr[AP_BIT]),
      .burst_len(blen),
      .row_in   (addr),
      .is_open  (bank_open[b]),
      .row      (open_rows[b*ROW_W +: ROW_W]),
      .ap_pend  (burst_pend[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_val   <= '0;
      cmd_ok     <= 1'b0;
      viol       <= 1'b0;
      viol_cause <= CAUSE_NONE;
      wr_left    <= '0;
      byte_wr_en <= '0;
    end else begin
      cmd_ok     <= accept;
      viol       <= (cause != CAUSE_NONE);
      viol_cause <= cause;
      if (accept && cmd == CMD_MODE) mode_val <= {ba, addr};
      // lane enables for the running write window
      byte_wr_en <= (wr_left != '0) ? ~dm : '0;
      if (accept && cmd == CMD_WR) begin
        wr_left <= blen;
      end else if (wr_left != '0) begin
        wr_left <= wr_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
  parameter int NBANK = 4,
  parameter int ROW_W = 13,
  parameter int LANES = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cs_n,
  input logic                   ras_n,
  input logic                   cas_n,
  input logic                   we_n,
  input logic [LANES-1:0]       dm,
  input logic [NBANK-1:0]       bank_open,
  input logic [NBANK*ROW_W-1:0] open_rows,
  input logic [NBANK-1:0]       burst_pend,
  input logic                   mode_wait,
  input logic [LANES-1:0]       byte_wr_en,
  input logic                   cmd_ok,
  input logic                   viol,
  input logic [2:0]             viol_cause
);
  logic pin_idle, pin_load;
  assign pin_idle = cs_n || (ras_n && cas_n && we_n);
  assign pin_load = !cs_n && !ras_n && !cas_n && !we_n;

  a_r1_idle_keeps_banks: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_idle) && $past(burst_pend) == '0) |-> bank_open == $past(bank_open));

  a_r10_ok_viol_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ok && viol));

  a_r8_pend_on_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_pend & ~bank_open) == '0);

  a_r5_load_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok && $past(pin_load)) |-> $past(bank_open) == '0);

  a_r6_settle_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_wait) && !$past(pin_idle)) |-> (viol && viol_cause == 3'd4));

  a_r3_rows_hold_on_viol: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> open_rows == $past(open_rows));

  a_r9_masked_lane_off: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_wr_en & $past(dm)) == '0);
endmodule

bind cmdbus_bank_monitor cbm_checker #(.NBANK(NBANK), .ROW_W(ROW_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .dm(dm), .bank_open(bank_open), .open_rows(open_rows), .burst_pend(burst_pend),
  .mode_wait(mode_wait), .byte_wr_en(byte_wr_en), .cmd_ok(cmd_ok), .viol(viol),
  .viol_cause(viol_cause)
);

// File: tb/cmdbus_bank_monitor_test.sv
module cmdbus_bank_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [1:0]  dm = 2'b11;
  logic [3:0]  mrd_wait = 4'd3;
  logic [3:0]  bank_open, burst_pend;
  logic [51:0] open_rows;
  logic [14:0] mode_val;
  logic        mode_wait, cmd_ok, viol;
  logic [1:0]  byte_wr_en;
  logic [2:0]  viol_cause;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmdbus_bank_monitor uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .dm(dm), .mrd_wait(mrd_wait), .bank_open(bank_open),
    .open_rows(open_rows), .burst_pend(burst_pend), .mode_val(mode_val),
    .mode_wait(mode_wait), .byte_wr_en(byte_wr_en), .cmd_ok(cmd_ok), .viol(viol),
    .viol_cause(viol_cause)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive pins at a falling edge, return at the next falling edge
  task automatic pins(logic c, logic r, logic a, logic w, logic [1:0] b, logic [12:0] ad);
    cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = b; addr = ad;
    @(negedge clk);
  endtask
  task automatic nop();                  pins(0, 1, 1, 1, 0, 0); endtask
  task automatic desel();                pins(1, 0, 0, 0, 0, 0); endtask
  task automatic act(logic [1:0] b, logic [12:0] r); pins(0, 0, 1, 1, b, r); endtask
  task automatic rd(logic [1:0] b, logic ap); pins(0, 1, 0, 1, b, {2'b0, ap, 10'h004}); endtask
  task automatic wr(logic [1:0] b, logic ap); pins(0, 1, 0, 0, b, {2'b0, ap, 10'h008}); endtask
  task automatic pre(logic [1:0] b, logic all); pins(0, 0, 1, 0, b, {2'b0, all, 10'h0}); endtask
  task automatic load(logic [14:0] v);    pins(0, 0, 0, 0, v[14:13], v[12:0]); endtask

  task automatic t_reset();
    chk("R2 bank_open", bank_open, 0);
    chk("R2 burst_pend", burst_pend, 0);
    chk("R2 flags", {viol, cmd_ok, mode_wait, byte_wr_en, viol_cause}, 0);
    chk("R2 mode_val", mode_val, 0);
  endtask

  task automatic t_load_and_settle();
    mrd_wait = 4'd3;
    load(15'h0032);
    chk("R5 mode latched", mode_val, 15'h0032);
    chk("R10 ok pulse", {cmd_ok, viol}, 2'b10);
    chk("R6 window open", mode_wait, 1);
    act(2'd0, 13'h011);
    chk("R6 blocked k+1", {viol, viol_cause, bank_open}, {1'b1, 3'd4, 4'h0});
    act(2'd0, 13'h011);
    chk("R6 blocked k+2", {viol, viol_cause, bank_open}, {1'b1, 3'd4, 4'h0});
    act(2'd1, 13'h155);
    chk("R6 free at k+3", {viol, cmd_ok}, 2'b01);
    chk("R3 opened", bank_open, 4'b0010);
    chk("R3 row", open_rows[13 +: 13], 13'h155);
  endtask

  task automatic t_activate_precharge();
    act(2'd1, 13'h0F0);
    chk("R3 act open bank", {viol, viol_cause}, {1'b1, 3'd2});
    chk("R3 row kept", open_rows[13 +: 13], 13'h155);
    nop();
    chk("R10 pulse ends", viol, 0);
    act(2'd2, 13'h0AA);
    chk("R3 two open", bank_open, 4'b0110);
    pre(2'd1, 1'b0);
    chk("R4 single close", bank_open, 4'b0100);
    pre(2'd3, 1'b0);
    chk("R4 idle precharge", {bank_open, viol, cmd_ok}, {4'b0100, 1'b0, 1'b1});
    load(15'h0033);
    chk("R5 load while open", {viol, viol_cause, mode_val}, {1'b1, 3'd1, 15'h0032});
    pre(2'd0, 1'b1);
    chk("R4 all close", bank_open, 4'b0000);
  endtask

  task automatic t_idle_access();
    rd(2'd0, 1'b0);
    chk("R7 read idle", {viol, viol_cause, bank_open}, {1'b1, 3'd3, 4'h0});
    wr(2'd3, 1'b1);
    chk("R7 write idle", {viol, viol_cause, burst_pend}, {1'b1, 3'd3, 4'h0});
  endtask

  task automatic t_auto_short();
    // mode 0x32: code 2 -> 4 beats -> 2 cycles
    act(2'd0, 13'h007);
    rd(2'd0, 1'b1);
    chk("R8 pend set", {bank_open[0], burst_pend[0]}, 2'b11);
    desel();
    chk("R1 deselect keeps burst", {bank_open[0], burst_pend[0]}, 2'b11);
    pins(0, 0, 0, 1, 2'd0, 13'h0);  // unused encoding
    chk("R8 closed k+2", {bank_open[0], burst_pend[0]}, 2'b00);
    chk("R1 other no viol", {viol, cmd_ok}, 2'b00);
    act(2'd0, 13'h007);
    rd(2'd0, 1'b0);
    nop(); nop(); nop();
    chk("R8 no ap stays open", bank_open[0], 1);
    pre(2'd0, 1'b1);
  endtask

  task automatic t_write_window();
    mrd_wait = 4'd1;
    load(15'h0033);                   // code 3 -> 8 beats -> 4 cycles
    act(2'd2, 13'h1AB);
    chk("R6 no window at W=1", {cmd_ok, viol, bank_open}, {1'b1, 1'b0, 4'b0100});
    dm = 2'b00;
    wr(2'd2, 1'b1);
    chk("R9 command edge", byte_wr_en, 2'b00);
    dm = 2'b00; nop(); chk("R9 beat1", byte_wr_en, 2'b11);
    dm = 2'b01; nop(); chk("R9 beat2", byte_wr_en, 2'b10);
    dm = 2'b10; nop(); chk("R9 beat3", byte_wr_en, 2'b01);
    chk("R8 open at k+3", bank_open[2], 1);
    dm = 2'b11; nop(); chk("R9 beat4", byte_wr_en, 2'b00);
    chk("R8 closed at k+4", bank_open[2], 0);
    dm = 2'b00; nop(); chk("R9 after window", byte_wr_en, 2'b00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load_and_settle();
    t_activate_precharge();
    t_idle_access();
    t_auto_short();
    t_write_window();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule